// File: doc/BRIEF.md
# Physical Register State Checker

This block keeps two state bits for every physical register of an out-of-order core. The ready bit means the register's value has been produced. The free bit means the register is sitting in the freelist. Three event ports from the pipeline drive these bits:

- Rename reports each register it takes from the freelist.
- Writeback reports each register it is about to write.
- Retirement reports each stale register it hands back to the freelist.

At every writeback the block checks that the destination register is legal. A legal destination has been allocated and not yet written, so both of its bits are clear. A corrupted destination name, or a corrupted freelist entry, breaks that rule at writeback time. When it does, the block reports a fault that names the register and the bit that was wrong.

Several events may arrive in the same cycle. The block applies them in a fixed order: first the pop, then the writeback check, then the release. The block also brings out its full ready and free vectors, so the surrounding logic can observe the state it keeps.

Top module: `prs_state_checker`

## Requirements
- R1: After reset, registers numbered below NUM_ARCH (default 8) have ready=1 and free=0. All other registers have ready=0 and free=1. faultValid is 0.
- R2: A pop (popValid=1) clears both the ready bit and the free bit of popTag. The change is visible on readyVec/freeVec one cycle later.
- R3: A release (relValid=1) sets the free bit of relTag and leaves its ready bit unchanged.
- R4: A writeback to a register with ready=0 and free=0 sets that register's ready bit and raises no fault.
- R5: A writeback to a register whose ready bit is set raises faultValid one cycle later. In that cycle faultTag equals the written register and faultRdyErr=1. The register's state does not change.
- R6: A writeback to a register whose free bit is set raises faultValid one cycle later with faultFreeErr=1, and leaves the register's state unchanged.
- R7: When a register has both bits set, a writeback to it reports faultRdyErr=1 and faultFreeErr=1 together.
- R8: A pop and a writeback to the same register in one cycle are checked against the state after the pop, so the writeback passes and ready ends at 1.
- R9: A writeback and a release to the same register in one cycle are checked before the release takes effect. After a passing check the register ends with ready=1 and free=1.
- R10: faultValid is 1 only in the cycle that follows a faulting writeback. It is 0 after a cycle with no writeback.
- R11: A pop and a release to the same register in one cycle leave that register with ready=0 and free=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| popValid | input | 1 | Rename took a register from the freelist |
| popTag | input | TAG_W | Register taken by rename |
| wbValid | input | 1 | Writeback to a register |
| wbTag | input | TAG_W | Register being written |
| relValid | input | 1 | Retirement returns a register to the freelist |
| relTag | input | TAG_W | Register being returned |
| faultValid | output | 1 | A writeback failed its check in the previous cycle |
| faultTag | output | TAG_W | Register of the failed writeback |
| faultRdyErr | output | 1 | The failed writeback found ready set |
| faultFreeErr | output | 1 | The failed writeback found free set |
| readyVec | output | NUM_PREGS | Ready bit of every register |
| freeVec | output | NUM_PREGS | Free bit of every register |

## Verification
The assertions assume that the event ports are held low during reset. They also assume that every tag lies below NUM_PREGS, so that the indexed state bits exist. The stimulus keeps within both limits: it drives all valids low until reset is released, and it draws every tag modulo the register count. The random phase deliberately produces colliding pop, writeback and release tags in the same cycle, and writebacks to illegal registers, so the ordering rules and the fault paths are exercised beyond the directed cases.

// File: rtl/prs_pkg.sv
package prs_pkg;

  // Strobes from the writeback control to the state array.
  typedef struct packed {
    logic popEn;    // clear ready and free of the popped tag
    logic wbSetEn;  // writeback passed its check: set ready
    logic relEn;    // set free of the released tag
  } prs_strobe_t;

endpackage

// File: rtl/prs_state_array.sv
module prs_state_array
  import prs_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  parameter int NUM_ARCH  = 8,
  localparam int TAG_W    = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  prs_strobe_t          strobe,
  input  logic [TAG_W-1:0]     popTag,
  input  logic [TAG_W-1:0]     wbTag,
  input  logic [TAG_W-1:0]     relTag,
  output logic                 viewRdy,
  output logic                 viewFree,
  output logic [NUM_PREGS-1:0] readyVec,
  output logic [NUM_PREGS-1:0] freeVec
);

  logic [NUM_PREGS-1:0] readyQ;
  logic [NUM_PREGS-1:0] freeQ;
  logic                 popHitsWb;

  // The writeback check sees the state as it stands after a same-cycle pop.
  assign popHitsWb = strobe.popEn && (popTag == wbTag);
  assign viewRdy   = popHitsWb ? 1'b0 : readyQ[wbTag];
  assign viewFree  = popHitsWb ? 1'b0 : freeQ[wbTag];

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
    localparam logic RST_RDY  = (g < NUM_ARCH);
    localparam logic RST_FREE = (g >= NUM_ARCH);
    logic rdyNext;
    logic freeNext;

    // Events are applied in the order pop, writeback, release.
    always_comb begin
      rdyNext  = readyQ[g];
      freeNext = freeQ[g];
      if (strobe.popEn && popTag == TAG_W'(g)) begin
        rdyNext  = 1'b0;
        freeNext = 1'b0;
      end
      if (strobe.wbSetEn && wbTag == TAG_W'(g)) rdyNext = 1'b1;
      if (strobe.relEn && relTag == TAG_W'(g)) freeNext = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        readyQ[g] <= RST_RDY;
        freeQ[g]  <= RST_FREE;
      end else begin
        readyQ[g] <= rdyNext;
        freeQ[g]  <= freeNext;
      end
    end
  end

  assign readyVec = readyQ;
  assign freeVec  = freeQ;

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popEn && !strobe.wbSetEn && !strobe.relEn)
      |=> (!readyQ[$past(popTag)] && !freeQ[$past(popTag)])); // R2

  AST_REL_SETS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relEn |=> freeQ[$past(relTag)]); // R3

  AST_WB_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wbSetEn |=> readyQ[$past(wbTag)]); // R4

  AST_POP_REL_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popEn && strobe.relEn && popTag == relTag && !strobe.wbSetEn)
      |=> (freeQ[$past(relTag)] && !readyQ[$past(relTag)])); // R11

endmodule

// File: rtl/prs_wb_ctrl.sv
module prs_wb_ctrl
  import prs_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  localparam int TAG_W    = $clog2(NUM_PREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             popValid,
  input  logic             wbValid,
  input  logic             relValid,
  input  logic [TAG_W-1:0] wbTag,
  input  logic             viewRdy,
  input  logic             viewFree,
  output prs_strobe_t      strobe,
  output logic             faultValid,
  output logic [TAG_W-1:0] faultTag,
  output logic             faultRdyErr,
  output logic             faultFreeErr
);

  logic rdyErr;
  logic freeErr;

  assign rdyErr  = wbValid && viewRdy;
  assign freeErr = wbValid && viewFree;

  always_comb begin
    strobe.popEn   = popValid;
    strobe.wbSetEn = wbValid && !rdyErr && !freeErr;
    strobe.relEn   = relValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultValid   <= 1'b0;
      faultTag     <= '0;
      faultRdyErr  <= 1'b0;
      faultFreeErr <= 1'b0;
    end else begin
      faultValid   <= rdyErr || freeErr;
      faultTag     <= wbTag;
      faultRdyErr  <= rdyErr;
      faultFreeErr <= freeErr;
    end
  end

  AST_FAULT_NEEDS_WB: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(wbValid)); // R10

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultRdyErr || faultFreeErr)); // R5

  AST_NO_SET_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !$past(strobe.wbSetEn)); // R6

endmodule

// File: rtl/prs_state_checker.sv
module prs_state_checker
  import prs_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  parameter int NUM_ARCH  = 8,
  localparam int TAG_W    = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 popValid,
  input  logic [TAG_W-1:0]     popTag,
  input  logic                 wbValid,
  input  logic [TAG_W-1:0]     wbTag,
  input  logic                 relValid,
  input  logic [TAG_W-1:0]     relTag,
  output logic                 faultValid,
  output logic [TAG_W-1:0]     faultTag,
  output logic                 faultRdyErr,
  output logic                 faultFreeErr,
  output logic [NUM_PREGS-1:0] readyVec,
  output logic [NUM_PREGS-1:0] freeVec
);

  prs_strobe_t strobe;
  logic        viewRdy;
  logic        viewFree;

  prs_wb_ctrl #(.NUM_PREGS(NUM_PREGS)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .popValid     (popValid),
    .wbValid      (wbValid),
    .relValid     (relValid),
    .wbTag        (wbTag),
    .viewRdy      (viewRdy),
    .viewFree     (viewFree),
    .strobe       (strobe),
    .faultValid   (faultValid),
    .faultTag     (faultTag),
    .faultRdyErr  (faultRdyErr),
    .faultFreeErr (faultFreeErr)
  );

  prs_state_array #(.NUM_PREGS(NUM_PREGS), .NUM_ARCH(NUM_ARCH)) i_state (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .popTag   (popTag),
    .wbTag    (wbTag),
    .relTag   (relTag),
    .viewRdy  (viewRdy),
    .viewFree (viewFree),
    .readyVec (readyVec),
    .freeVec  (freeVec)
  );

endmodule

// File: tb/test_prs_state_checker.sv
module test_prs_state_checker;
  localparam int NP = 16;
  localparam int NA = 8;
  localparam int TW = $clog2(NP);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, popValid, wbValid, relValid;
  logic [TW-1:0] popTag, wbTag, relTag;
  logic faultValid, faultRdyErr, faultFreeErr;
  logic [TW-1:0] faultTag;
  logic [NP-1:0] readyVec, freeVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NP-1:0] mRdy, mFree;

  prs_state_checker #(.NUM_PREGS(NP), .NUM_ARCH(NA)) i_prs_state_checker (
    .clk(clk), .rstN(rstN),
    .popValid(popValid), .popTag(popTag),
    .wbValid(wbValid), .wbTag(wbTag),
    .relValid(relValid), .relTag(relTag),
    .faultValid(faultValid), .faultTag(faultTag),
    .faultRdyErr(faultRdyErr), .faultFreeErr(faultFreeErr),
    .readyVec(readyVec), .freeVec(freeVec)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; expected state from the requirements.
  task automatic cyc(input logic pv, input logic [TW-1:0] pt,
                     input logic wv, input logic [TW-1:0] wt,
                     input logic rv, input logic [TW-1:0] rt,
                     input string req);
    logic eR, eF;
    popValid = pv; popTag = pt;
    wbValid  = wv; wbTag  = wt;
    relValid = rv; relTag = rt;
    if (pv) begin mRdy[pt] = 1'b0; mFree[pt] = 1'b0; end   // pop first
    eR = wv && mRdy[wt];                                    // then check
    eF = wv && mFree[wt];
    if (wv && !eR && !eF) mRdy[wt] = 1'b1;
    if (rv) mFree[rt] = 1'b1;                               // release last
    @(posedge clk);
    @(negedge clk);
    popValid = 1'b0; wbValid = 1'b0; relValid = 1'b0;
    chk(req, "faultValid", 32'(faultValid), 32'(eR || eF));
    if (eR || eF) begin
      chk(req, "faultTag", 32'(faultTag), 32'(wt));
      chk(req, "faultRdyErr", 32'(faultRdyErr), 32'(eR));
      chk(req, "faultFreeErr", 32'(faultFreeErr), 32'(eF));
    end
    chk(req, "readyVec", 32'(readyVec), 32'(mRdy));
    chk(req, "freeVec", 32'(freeVec), 32'(mFree));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; popValid = 1'b0; wbValid = 1'b0; relValid = 1'b0;
    popTag = '0; wbTag = '0; relTag = '0;
    for (int i = 0; i < NP; i++) begin
      mRdy[i]  = (i < NA);
      mFree[i] = (i >= NA);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1", "readyVec", 32'(readyVec), 32'(mRdy));
    chk("R1", "freeVec", 32'(freeVec), 32'(mFree));
    chk("R1", "faultValid", 32'(faultValid), 32'd0);

    cyc(1, 4'd10, 0, 4'd0, 0, 4'd0, "R2 pop");
    cyc(0, 4'd0, 1, 4'd10, 0, 4'd0, "R4 legal writeback");
    cyc(0, 4'd0, 1, 4'd10, 0, 4'd0, "R5 ready already set");
    cyc(0, 4'd0, 1, 4'd12, 0, 4'd0, "R6 free set");
    cyc(0, 4'd0, 0, 4'd0, 1, 4'd3, "R3 release");
    cyc(0, 4'd0, 1, 4'd3, 0, 4'd0, "R7 both bits set");
    cyc(1, 4'd13, 1, 4'd13, 0, 4'd0, "R8 pop and writeback same tag");
    cyc(1, 4'd14, 0, 4'd0, 0, 4'd0, "R9 setup pop");
    cyc(0, 4'd0, 1, 4'd14, 1, 4'd14, "R9 writeback and release same tag");
    cyc(1, 4'd9, 0, 4'd0, 1, 4'd9, "R11 pop and release same tag");
    cyc(0, 4'd0, 0, 4'd0, 0, 4'd0, "R10 idle after fault-free cycle");
    cyc(0, 4'd0, 1, 4'd12, 0, 4'd0, "R10 fault cycle");
    cyc(0, 4'd0, 0, 4'd0, 0, 4'd0, "R10 fault drops");

    for (int n = 0; n < 400; n++) begin
      cyc(1'($urandom % 2), TW'($urandom % NP),
          1'($urandom % 2), TW'($urandom % NP),
          1'($urandom % 3 == 0), TW'($urandom % NP),
          "random R2 R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule